// File: doc/BRIEF.md
# Prioritized Exception Arbiter

This block watches a set of interrupt request flags and a small group of trap request lines. Each cycle it picks the single most urgent request that is allowed to interrupt the CPU at its present priority level. It registers that winner and presents it to the CPU as a vector number together with the priority level the CPU must move to. Interrupts carry a 3-bit priority that software programs. Traps carry fixed priorities placed above every interrupt level. When priorities are equal, a fixed order decides, and the lower vector index wins.

The vector space begins with the traps: trap `j` is vector `j`. Interrupt `i` follows as vector `N_TRAP + i`. When the take strobe fires, the block also raises an acknowledge for the served source, so the flag owner can clear it. The block has no data stream, so every pin is a plain control or status signal with no handshake. The CPU is expected to load `new_lvl` as its level on the take pulse. The source is expected to drop its flag on the acknowledge. The block leaves one idle cycle after every take so that both updates are in place before it arbitrates again.

Top module: `exc_arbiter`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `take`, `irq_ack` and `trap_ack` are all 0.
- R2: A source is a candidate only when it is requested and its priority is strictly greater than `cur_lvl`. For an interrupt, requested means both its pending bit and its enable bit are 1. For a trap, requested means its request line is 1. A candidate at or below `cur_lvl` is never taken.
- R3: An interrupt whose programmed priority is 0 is never taken, at any `cur_lvl`.
- R4: Among the candidates, the one with the numerically highest priority wins.
- R5: When candidates share the highest priority, the one with the lowest vector index wins.
- R6: Trap `j` is vector `j` and has the fixed priority `TRAP_TOP - j`, which is 15 - j by default, so every trap outranks every interrupt. Interrupt `i` is vector `N_TRAP + i`, and its priority is field `irq_prio[3*i +: 3]`.
- R7: In the cycle `take` is 1, `vec_idx` is the winner's vector index and `new_lvl` is the winner's priority. Both are produced one clock edge after the inputs that selected them.
- R8: `take` is never 1 in two consecutive cycles. If a request is held unchanged, `take` alternates 1, 0, 1, 0.
- R9: `irq_ack` and `trap_ack` are each one-hot or zero. Only the winner's bit is set, and only in the cycle `take` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pend | input | N_IRQ | Interrupt pending flags |
| irq_en | input | N_IRQ | Per-interrupt enables |
| irq_prio | input | 3*N_IRQ | Packed 3-bit priority per interrupt |
| trap_req | input | N_TRAP | Trap request lines |
| cur_lvl | input | 4 | Current CPU priority level |
| take | output | 1 | Single-cycle exception strobe |
| vec_idx | output | VEC_W | Winning vector index |
| new_lvl | output | 4 | Priority level the CPU adopts |
| irq_ack | output | N_IRQ | One-hot acknowledge of the served interrupt |
| trap_ack | output | N_TRAP | One-hot acknowledge of the served trap |

## Verification
A fault in the candidate filter or the priority search appears one edge after the inputs are applied. It shows up as a wrong `vec_idx` or `new_lvl`, or as a take that should not fire or one that is missing. A fault in the take register shows up as back-to-back strobes when a request is held. A fault in the acknowledge decode appears in the same cycle as the strobe, as a bit on a source other than the winner. The stimulus includes ties, level gating with the priority exactly equal to `cur_lvl`, a trap competing with a priority-7 interrupt, and traps that are masked by a high CPU level.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int LVL_W   = 4;
  localparam int UPRIO_W = 3;
  typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/exc_candidates.sv
module exc_candidates
  import exc_pkg::*;
#(
  parameter int N_IRQ    = 54,
  parameter int N_TRAP   = 4,
  parameter int TRAP_TOP = 15,
  localparam int N_VEC   = N_TRAP + N_IRQ
) (
  input  logic [N_IRQ-1:0]             irq_pend,
  input  logic [N_IRQ-1:0]             irq_en,
  input  logic [UPRIO_W*N_IRQ-1:0]     irq_prio,
  input  logic [N_TRAP-1:0]            trap_req,
  input  lvl_t                         cur_lvl,
  output logic [N_VEC-1:0][LVL_W-1:0]  cand_prio
);
  // A zero entry means "not a candidate": any candidate's priority exceeds cur_lvl >= 0.
  for (genvar j = 0; j < N_TRAP; j++) begin : g_trap
    localparam lvl_t FIXED = LVL_W'(TRAP_TOP - j);
    assign cand_prio[j] = (trap_req[j] && (FIXED > cur_lvl)) ? FIXED : '0;
  end

  for (genvar i = 0; i < N_IRQ; i++) begin : g_irq
    lvl_t p;
    assign p = {1'b0, irq_prio[UPRIO_W*i +: UPRIO_W]};
    assign cand_prio[N_TRAP+i] = (irq_pend[i] && irq_en[i] && (p > cur_lvl)) ? p : '0;
  end
endmodule

// File: rtl/exc_pick.sv
module exc_pick
  import exc_pkg::*;
#(
  parameter int N_VEC  = 58,
  localparam int VEC_W = $clog2(N_VEC)
) (
  input  logic [N_VEC-1:0][LVL_W-1:0] cand_prio,
  output logic                        found,
  output logic [VEC_W-1:0]            win_idx,
  output lvl_t                        win_prio
);
  // Strict compare while scanning upward keeps the lowest index on ties.
  always_comb begin
    win_prio = '0;
    win_idx  = '0;
    for (int i = 0; i < N_VEC; i++) begin
      if (cand_prio[i] > win_prio) begin
        win_prio = cand_prio[i];
        win_idx  = VEC_W'(i);
      end
    end
    found = (win_prio != '0);
  end
endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_pkg::*;
#(
  parameter int N_IRQ    = 54,
  parameter int N_TRAP   = 4,
  parameter int TRAP_TOP = 15,
  localparam int N_VEC   = N_TRAP + N_IRQ,
  localparam int VEC_W   = $clog2(N_VEC)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_IRQ-1:0]         irq_pend,
  input  logic [N_IRQ-1:0]         irq_en,
  input  logic [UPRIO_W*N_IRQ-1:0] irq_prio,
  input  logic [N_TRAP-1:0]        trap_req,
  input  logic [LVL_W-1:0]         cur_lvl,
  output logic                     take,
  output logic [VEC_W-1:0]         vec_idx,
  output logic [LVL_W-1:0]         new_lvl,
  output logic [N_IRQ-1:0]         irq_ack,
  output logic [N_TRAP-1:0]        trap_ack
);
  logic [N_VEC-1:0][LVL_W-1:0] cand_prio;
  logic             found;
  logic [VEC_W-1:0] win_idx;
  lvl_t             win_prio;

  exc_candidates #(.N_IRQ(N_IRQ), .N_TRAP(N_TRAP), .TRAP_TOP(TRAP_TOP)) u_cand (
    .irq_pend(irq_pend), .irq_en(irq_en), .irq_prio(irq_prio),
    .trap_req(trap_req), .cur_lvl(cur_lvl), .cand_prio(cand_prio)
  );

  exc_pick #(.N_VEC(N_VEC)) u_pick (
    .cand_prio(cand_prio), .found(found), .win_idx(win_idx), .win_prio(win_prio)
  );

  // One idle cycle after each take lets the CPU level and the source flag update.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take    <= 1'b0;
      vec_idx <= '0;
      new_lvl <= '0;
    end else begin
      take <= found && !take;
      if (found && !take) begin
        vec_idx <= win_idx;
        new_lvl <= win_prio;
      end
    end
  end

  for (genvar j = 0; j < N_TRAP; j++) begin : g_tack
    assign trap_ack[j] = take && (vec_idx == VEC_W'(j));
  end
  for (genvar i = 0; i < N_IRQ; i++) begin : g_iack
    assign irq_ack[i] = take && (vec_idx == VEC_W'(N_TRAP + i));
  end

  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !take);

  assert_level_raised_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(take) |-> (new_lvl > $past(cur_lvl)));

  assert_ack_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq_ack, trap_ack}));

  assert_ack_with_take_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|{irq_ack, trap_ack}) |-> take);

  assert_trap_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(take) && (vec_idx >= VEC_W'(N_TRAP)) && ($past(cur_lvl) < LVL_W'(8)))
      |-> ($past(trap_req) == '0));
endmodule

// File: tb/exc_arbiter_tb.sv
module exc_arbiter_tb;
  localparam int N_IRQ  = 54;
  localparam int N_TRAP = 4;
  localparam int VEC_W  = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N_IRQ-1:0]   irq_pend = '0;
  logic [N_IRQ-1:0]   irq_en   = '0;
  logic [3*N_IRQ-1:0] irq_prio = '0;
  logic [N_TRAP-1:0]  trap_req = '0;
  logic [3:0]         cur_lvl  = '0;
  logic               take;
  logic [VEC_W-1:0]   vec_idx;
  logic [3:0]         new_lvl;
  logic [N_IRQ-1:0]   irq_ack;
  logic [N_TRAP-1:0]  trap_ack;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  exc_arbiter u_dut (
    .clk(clk), .rst_n(rst_n), .irq_pend(irq_pend), .irq_en(irq_en),
    .irq_prio(irq_prio), .trap_req(trap_req), .cur_lvl(cur_lvl),
    .take(take), .vec_idx(vec_idx), .new_lvl(new_lvl),
    .irq_ack(irq_ack), .trap_ack(trap_ack)
  );

  typedef struct packed {
    logic [6:0] a_idx;   // 127 = unused
    logic [2:0] a_p;
    logic [6:0] b_idx;
    logic [2:0] b_p;
    logic [3:0] trap;
    logic [3:0] lvl;
    logic       e_take;
    logic [5:0] e_vec;
    logic [3:0] e_lvl;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t TABLE [NV] = '{
    '{7'd5,  3'd3, 7'd127, 3'd0, 4'b0000, 4'd0, 1'b1, 6'd9,  4'd3},  // R2 R7
    '{7'd5,  3'd3, 7'd127, 3'd0, 4'b0000, 4'd3, 1'b0, 6'd0,  4'd0},  // R2 equal level
    '{7'd5,  3'd0, 7'd127, 3'd0, 4'b0000, 4'd0, 1'b0, 6'd0,  4'd0},  // R3
    '{7'd10, 3'd2, 7'd3,   3'd6, 4'b0000, 4'd1, 1'b1, 6'd7,  4'd6},  // R4
    '{7'd20, 3'd4, 7'd8,   3'd4, 4'b0000, 4'd0, 1'b1, 6'd12, 4'd4},  // R5
    '{7'd53, 3'd7, 7'd127, 3'd0, 4'b0100, 4'd7, 1'b1, 6'd2,  4'd13}, // R6
    '{7'd127,3'd0, 7'd127, 3'd0, 4'b1010, 4'd0, 1'b1, 6'd1,  4'd14}, // R6 R5
    '{7'd127,3'd0, 7'd127, 3'd0, 4'b0001, 4'd15,1'b0, 6'd0,  4'd0},  // R2 trap gated
    '{7'd0,  3'd1, 7'd127, 3'd0, 4'b0000, 4'd0, 1'b1, 6'd4,  4'd1}   // R7 lowest irq
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_inputs();
    irq_pend = '0; irq_en = '0; irq_prio = '0; trap_req = '0; cur_lvl = '0;
  endtask

  task automatic set_irq(input int idx, input int p, input bit en);
    irq_pend[idx] = 1'b1;
    irq_en[idx]   = en;
    irq_prio[3*idx +: 3] = 3'(p);
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R1: reset state, including while reset is held
    chk(take == 0 && irq_ack == 0 && trap_ack == 0, "R1", int'(take), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(take == 0 && irq_ack == 0 && trap_ack == 0, "R1", int'(take), 0);

    for (int k = 0; k < NV; k++) begin
      logic [N_IRQ-1:0]  e_iack;
      logic [N_TRAP-1:0] e_tack;
      clear_inputs();
      if (TABLE[k].a_idx != 7'd127) set_irq(int'(TABLE[k].a_idx), int'(TABLE[k].a_p), 1'b1);
      if (TABLE[k].b_idx != 7'd127) set_irq(int'(TABLE[k].b_idx), int'(TABLE[k].b_p), 1'b1);
      trap_req = TABLE[k].trap;
      cur_lvl  = TABLE[k].lvl;
      @(posedge clk); @(negedge clk);
      chk(take == TABLE[k].e_take, "R2/R4 take", int'(take), int'(TABLE[k].e_take));
      e_iack = '0; e_tack = '0;
      if (TABLE[k].e_take) begin
        chk(vec_idx == TABLE[k].e_vec, "R5/R6 vec", int'(vec_idx), int'(TABLE[k].e_vec));
        chk(new_lvl == TABLE[k].e_lvl, "R7 lvl", int'(new_lvl), int'(TABLE[k].e_lvl));
        if (TABLE[k].e_vec < 6'(N_TRAP)) e_tack[TABLE[k].e_vec] = 1'b1;
        else e_iack[TABLE[k].e_vec - 6'(N_TRAP)] = 1'b1;
      end
      chk(irq_ack == e_iack && trap_ack == e_tack, "R9 ack", int'($countones(irq_ack)), int'($countones(e_iack)));
      clear_inputs();
      @(posedge clk); @(negedge clk);
      chk(take == 0, "R8 idle", int'(take), 0);
      @(posedge clk); @(negedge clk);
    end

    // R2: pending but disabled source is ignored
    clear_inputs();
    set_irq(30, 7, 1'b0);
    @(posedge clk); @(negedge clk);
    chk(take == 0, "R2 disabled", int'(take), 0);

    // R8: held request alternates 1,0,1,0
    clear_inputs();
    set_irq(2, 5, 1'b1);
    for (int c = 0; c < 4; c++) begin
      @(posedge clk); @(negedge clk);
      chk(take == ((c % 2) == 0), "R8 alternate", int'(take), int'((c % 2) == 0));
    end
    clear_inputs();
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);

    // R6: trap beats priority-7 interrupt at low vector index
    set_irq(0, 7, 1'b1);
    trap_req = 4'b1000;
    @(posedge clk); @(negedge clk);
    chk(take && vec_idx == 6'd3 && new_lvl == 4'd12, "R6 trap over irq", int'(vec_idx), 3);
    clear_inputs();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule